// File: doc/BRIEF.md
# Rate-1/2 Convolutional Encoder, Constraint Length 7

This block encodes a serial bit stream for forward error correction on the transmit side of an OFDM wireless LAN modem. Each cycle it may accept one data bit, qualified by a valid strobe. For every accepted bit it emits a pair of coded bits. The pair is formed from the new bit together with a six-bit history of earlier accepted bits. The two coded bits come from the generator pair 133 and 171 (octal), combined by XOR.

The data input and the coded outputs are both registered, so the encoding logic sits between two register boundaries. The encoder has no feedback path. For that reason the parameter `PIPE_STAGES` can add register stages inside the XOR trees: these stages add latency and leave the coded sequence unchanged. A synchronous clear flushes the encoder back to its all-zero starting state. When the pair is serialised downstream, `code_a` is sent first and `code_b` second.

Top module: `conv_enc_k7`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid`, `code_a` and `code_b` are 0. The history register starts as all zeros.
- R2: Each bit accepted with `in_valid` high and `clr` low produces exactly one cycle of `out_valid` high. No `out_valid` appears without an accepted bit.
- R3: Form the window w[6:0] = {d, s5, s4, s3, s2, s1, s0}, where d is the new bit and s0 is the oldest history bit. Then `code_a` = XOR of w[6], w[4], w[3], w[1] and w[0] (mask 133 octal).
- R4: With the same window, `code_b` = XOR of w[6], w[5], w[4], w[3] and w[0] (mask 171 octal).
- R5: After each accepted bit the history becomes {d, s5..s1}, so s0 is dropped. Cycles with `in_valid` low leave the history unchanged.
- R6: Let E be the rising edge at which a bit is accepted. Its coded pair and `out_valid` appear right after rising edge E + 1 + `PIPE_STAGES`.
- R7: If `clr` is high at a rising edge, the history is zeroed and every bit still inside the block is discarded, including a bit presented on that same edge. None of these bits produces `out_valid`. Bits accepted later are encoded from the all-zero state.
- R8: `code_a` and `code_b` hold their previous values while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous flush to the all-zero state |
| in_valid | input | 1 | Qualifies `in_bit` |
| in_bit | input | 1 | Data bit to encode |
| out_valid | output | 1 | Coded pair valid |
| code_a | output | 1 | Coded bit from generator 133 octal, sent first |
| code_b | output | 1 | Coded bit from generator 171 octal, sent second |

## Verification
Let E be the edge that captures a bit. Its coded pair is due one plus `PIPE_STAGES` edges after E. The bench drives inputs on falling edges and samples outputs on falling edges. Each accepted bit is written into a timeline slot exactly 2 + `PIPE_STAGES` falling edges ahead, and every falling edge checks `out_valid` against its slot, so an early, late or extra pulse all show as a mismatch.

A clear erases the slots that the flushed bits would have occupied. This checks that all in-flight bits and the same-edge bit vanish. Every 7-bit window is swept after a clear, followed by a long pseudo-random run with gaps in `in_valid`.

// File: rtl/cenc_pkg.sv
package cenc_pkg;
   // Parity of a window under a tap mask.
   function automatic logic masked_parity(input logic [31:0] win, input logic [31:0] mask);
      return ^(win & mask);
   endfunction

   // Index of the first register stage inside the XOR trees.
   localparam int unsigned FIRST_STAGE = 0;
endpackage

// File: rtl/cenc_history.sv
module cenc_history #(
   parameter int unsigned K = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   input  logic         din,
   output logic [K-2:0] state
);
   localparam int unsigned SW = K - 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state <= '0;
      else if (clr)     state <= '0;
      else if (adv)     state <= {din, state[SW-1:1]};
   end
endmodule

// File: rtl/cenc_xor_pipe.sv
module cenc_xor_pipe #(
   parameter int unsigned K           = 7,
   parameter logic [K-1:0] GEN_A      = 7'o133,
   parameter logic [K-1:0] GEN_B      = 7'o171,
   parameter int unsigned PIPE_STAGES = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         win_v,
   input  logic [K-1:0] win,
   output logic         par_v,
   output logic         par_a,
   output logic         par_b
);
   import cenc_pkg::*;

   generate
      if (PIPE_STAGES == 0) begin : g_flat
         assign par_v = win_v;
         assign par_a = masked_parity(32'(win), 32'(GEN_A));
         assign par_b = masked_parity(32'(win), 32'(GEN_B));
      end else begin : g_split
         localparam int unsigned H = K / 2;
         logic [K-1:0] wa, wb;
         logic [3:0]   part;
         logic [PIPE_STAGES-1:0] v_q;
         logic [3:0]   p_q [PIPE_STAGES];

         assign wa   = win & GEN_A;
         assign wb   = win & GEN_B;
         assign part = {^wa[K-1:H], ^wa[H-1:0], ^wb[K-1:H], ^wb[H-1:0]};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      v_q <= '0;
            else if (flush)  v_q <= '0;
            else begin
               v_q[FIRST_STAGE] <= win_v;
               for (int i = 1; i < int'(PIPE_STAGES); i++) v_q[i] <= v_q[i-1];
            end
         end

         always_ff @(posedge clk) begin
            if (win_v) p_q[FIRST_STAGE] <= part;
            for (int i = 1; i < int'(PIPE_STAGES); i++) p_q[i] <= p_q[i-1];
         end

         assign par_v = v_q[PIPE_STAGES-1];
         assign par_a = p_q[PIPE_STAGES-1][3] ^ p_q[PIPE_STAGES-1][2];
         assign par_b = p_q[PIPE_STAGES-1][1] ^ p_q[PIPE_STAGES-1][0];
      end
   endgenerate
endmodule

// File: rtl/conv_enc_k7.sv
module conv_enc_k7 #(
   parameter int unsigned K           = 7,
   parameter logic [K-1:0] GEN_A      = 7'o133,
   parameter logic [K-1:0] GEN_B      = 7'o171,
   parameter int unsigned PIPE_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic in_valid,
   input  logic in_bit,
   output logic out_valid,
   output logic code_a,
   output logic code_b
);
   localparam int unsigned SW = K - 1;

   generate
      if (K < 3 || K > 16) begin : g_bad_k
         $error("conv_enc_k7: K out of range");
      end
      if (!GEN_A[K-1] || !GEN_B[K-1] || !GEN_A[0] || !GEN_B[0]) begin : g_bad_gen
         $error("conv_enc_k7: generators must tap both window ends");
      end
      if (PIPE_STAGES > 4) begin : g_bad_pipe
         $error("conv_enc_k7: PIPE_STAGES above 4");
      end
   endgenerate

   logic          in_v_q, in_d_q;
   logic [SW-1:0] enc_state;
   logic          par_v, par_a, par_b;

   // Input isolation register; clear drops the bit presented with it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_v_q <= 1'b0;
         in_d_q <= 1'b0;
      end else begin
         in_v_q <= in_valid && !clr;
         if (in_valid) in_d_q <= in_bit;
      end
   end

   cenc_history #(.K(K)) u_hist (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .adv(in_v_q), .din(in_d_q), .state(enc_state)
   );

   cenc_xor_pipe #(.K(K), .GEN_A(GEN_A), .GEN_B(GEN_B), .PIPE_STAGES(PIPE_STAGES)) u_xor (
      .clk(clk), .rst_n(rst_n), .flush(clr),
      .win_v(in_v_q), .win({in_d_q, enc_state}),
      .par_v(par_v), .par_a(par_a), .par_b(par_b)
   );

   // Output isolation register; bits move only with a valid pair.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         code_a    <= 1'b0;
         code_b    <= 1'b0;
      end else if (clr) begin
         out_valid <= 1'b0;
      end else begin
         out_valid <= par_v;
         if (par_v) begin
            code_a <= par_a;
            code_b <= par_b;
         end
      end
   end
endmodule

// File: rtl/cenc_checker.sv
module cenc_checker #(
   parameter int unsigned K = 7
) (
   input logic         clk,
   input logic         rst_n,
   input logic         clr,
   input logic         in_v_q,
   input logic [K-2:0] state,
   input logic         out_valid,
   input logic         code_a,
   input logic         code_b
);
   AST_CLR_ZEROES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (state == '0)); // R7
   AST_CLR_KILLS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !out_valid); // R7
   AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_v_q && !clr) |=> $stable(state)); // R5
   AST_SHIFT_ONE_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_v_q && !clr) |=> (state[K-3:0] == $past(state[K-2:1]))); // R5
   AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(code_a) && $stable(code_b))); // R8
endmodule

bind conv_enc_k7 cenc_checker #(.K(K)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .in_v_q(in_v_q),
   .state(enc_state), .out_valid(out_valid), .code_a(code_a), .code_b(code_b)
);

// File: tb/sim_conv_enc_k7.sv
`timescale 1ns/1ps
module sim_conv_enc_k7;
   localparam int K   = 7;
   localparam int PS  = 1;
   localparam int LAT = 2 + PS;
   localparam logic [6:0] MA = 7'b1011011; // R3 taps w6,w4,w3,w1,w0
   localparam logic [6:0] MB = 7'b1111001; // R4 taps w6,w5,w4,w3,w0

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
   logic out_valid, code_a, code_b;

   always #2.5 clk = ~clk;

   conv_enc_k7 #(.PIPE_STAGES(PS)) u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_bit(in_bit),
      .out_valid(out_valid), .code_a(code_a), .code_b(code_b)
   );

   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit exp_v [0:8191];
   bit exp_a [0:8191];
   bit exp_b [0:8191];
   logic [5:0] rs = '0;
   logic last_a = 1'b0, last_b = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   task automatic step(input bit v, input bit b, input bit c);
      logic [6:0] w;
      @(negedge clk);
      if (exp_v[cyc] || out_valid) begin
         chk(out_valid == exp_v[cyc], "R2/R6 out_valid timing", int'(out_valid), int'(exp_v[cyc]));
         if (exp_v[cyc] && out_valid) begin
            chk(code_a == exp_a[cyc], "R3 code_a", int'(code_a), int'(exp_a[cyc]));
            chk(code_b == exp_b[cyc], "R4 code_b", int'(code_b), int'(exp_b[cyc]));
         end
      end else begin
         chk(code_a == last_a && code_b == last_b, "R8 hold while idle",
             int'({code_a, code_b}), int'({last_a, last_b}));
      end
      if (out_valid) begin
         last_a = code_a;
         last_b = code_b;
      end
      in_valid = v; in_bit = b; clr = c;
      if (c) begin
         // R7: everything in flight and this bit vanish
         for (int i = 1; i <= LAT; i++) exp_v[cyc+i] = 1'b0;
         rs = '0;
      end else if (v) begin
         w = {b, rs};
         exp_v[cyc+LAT] = 1'b1;
         exp_a[cyc+LAT] = ^(w & MA);
         exp_b[cyc+LAT] = ^(w & MB);
         rs = {b, rs[5:1]}; // R5
      end
      cyc++;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] lf;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
      chk(code_a == 1'b0 && code_b == 1'b0, "R1 codes in reset", int'({code_a, code_b}), 0);
      rst_n = 1'b1;
      repeat (2) step(0, 0, 0);
      // R1: first bits encode from the all-zero state; impulse shows generator taps
      step(1, 1, 0);
      repeat (8) step(1, 0, 0);
      repeat (20) step(1, 1, 0);
      // R5: gaps in valid must not move history
      for (int i = 0; i < 30; i++) step(i % 3 == 0, i[1] ^ i[0], 0);
      // R7: clear with a bit presented on the same edge, stream in flight
      repeat (5) step(1, 1, 0);
      step(1, 1, 1);
      repeat (10) step(1, 0, 0);
      repeat (3) step(1, 1, 0);
      step(0, 0, 1);
      step(1, 1, 0);
      step(0, 0, 1);
      repeat (LAT + 2) step(0, 0, 0);
      // R3 R4: exhaustive sweep of all 7-bit windows from the zero state
      for (int p = 0; p < 128; p++) begin
         step(0, 0, 1);
         for (int j = 6; j >= 0; j--) step(1, p[j], 0);
      end
      // R2 R6: pseudo-random run with about one quarter idle cycles
      lf = 16'hACE1;
      for (int i = 0; i < 1500; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step(lf[3:2] != 2'b00, lf[7], i == 777);
      end
      repeat (LAT + 4) step(0, 0, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule